// File: doc/BRIEF.md
# Keyboard Gate-Command Trap Sequencer

This block sits beside the host I/O path to a legacy keyboard controller. It sees one decoded cycle at a time: a strobe, the port address, the direction and the write data. For every cycle aimed at the keyboard data port (60h) or the command/status port (64h), it makes two decisions. The first is whether the cycle is forwarded to the downstream controller. The second is whether a system-management interrupt (SMI) pulse is raised so that firmware can emulate the access.

On top of the per-port trap enables, the block follows the two-write gate-control command. That command is D1h written to the command port, followed by a byte written to the data port, and closed by FFh written to the command port. The cycles expected inside this sequence always reach the controller without a trap, so an interrupted handler never sees half of the command. A deviation ends the sequence early and is handled by the per-port enables. A separate enable can add an SMI whenever the sequence ends, whether normally or early. A flag shows that the sequence is in progress.

Top module: `kbd_gate_seq`

## Requirements
- R1: After reset the sequence-in-progress flag is 0, the SMI output is 0, and the block is idle.
- R2: When idle, a write of D1h to 64h is forwarded with no SMI, and the progress flag reads 1 from the next clock.
- R3: When idle, any other keyboard-port cycle stays idle. The trap enable is taken from trap_cfg: bit 3 for a 64h write, bit 2 for a 64h read, bit 1 for a 60h write and bit 0 for a 60h read. A set enable blocks forwarding and raises an SMI. A clear enable forwards the cycle with no SMI.
- R4: After D1h, a 60h write of any value is forwarded with no SMI, even when trap_cfg bit 1 is set. The sequence moves to its second step and the flag stays 1.
- R5: After D1h, a repeated D1h write to 64h is forwarded with no SMI, even when bit 3 is set. The sequence stays at its first step.
- R6: During the sequence, a 64h read keeps the current step and the flag. It is trapped (not forwarded, SMI raised) only if bit 2 is set, and is otherwise forwarded.
- R7: At the second step, an FFh write to 64h is forwarded, the flag clears, and an SMI is raised only if trap_cfg bit 7 is set.
- R8: Any other keyboard-port cycle during the sequence ends it and clears the flag. Forwarding follows that cycle's own per-port enable, as in R3. An SMI is raised when that enable is set or when bit 7 is set.
- R9: smi_pulse is high for exactly the one clock after an accepted strobe that raised it, and is low otherwise.
- R10: A clock with no strobe, or a strobe to any address other than 60h or 64h, forwards nothing, raises no SMI and leaves the sequence state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One-clock strobe marking a decoded I/O cycle |
| cyc_addr | input | ADDR_W | I/O port address of the cycle |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| cyc_wdata | input | DATA_W | Write data byte |
| trap_cfg | input | 8 | Trap enables: bit 0 60h read, bit 1 60h write, bit 2 64h read, bit 3 64h write, bit 7 SMI at end of sequence |
| fwd_en | output | 1 | Same-clock forward decision for the current cycle |
| smi_pulse | output | 1 | Registered one-clock SMI request |
| seq_active | output | 1 | Gate-command sequence in progress |

## Verification
A wrong internal step cannot be seen directly, because the progress flag reads the same at both steps of the sequence. The error shows at the first cycle whose handling depends on the step. A corrupted step makes a 60h write or a second D1h trap when it should be forwarded, or lets FFh end the sequence too early. The fwd_en mismatch appears in the same clock, and the SMI mismatch one clock later. The bench therefore keeps its own model of the step and drives long random cycle streams that are biased towards D1h, FFh and data-port writes. It compares every clock against that model, so a drifted step is caught within a cycle or two of the first cycle that tells the steps apart.

// File: rtl/kgs_pkg.sv
package kgs_pkg;

    // Position of each enable inside the trap configuration byte
    localparam int CFG_W       = 8;
    localparam int CFG_DAT_RD  = 0;
    localparam int CFG_DAT_WR  = 1;
    localparam int CFG_CMD_RD  = 2;
    localparam int CFG_CMD_WR  = 3;
    localparam int CFG_SEQ_SMI = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE1 = 2'd1,
        ST_GATE2 = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_CMD_WR = 3'd1,
        CYC_CMD_RD = 3'd2,
        CYC_DAT_WR = 3'd3,
        CYC_DAT_RD = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        seq_state_e state;
        logic       smi;
    } seq_regs_t;

endpackage

// File: rtl/kgs_decode.sv
module kgs_decode
    import kgs_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
    parameter logic [DATA_W-1:0] GATE_CMD  = 'hD1,
    parameter logic [DATA_W-1:0] END_CMD   = 'hFF
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    output cyc_kind_e         kind,
    output logic              is_gate_cmd,
    output logic              is_end_cmd
);

    logic hit_data;
    logic hit_cmd;

    assign hit_data = valid && (addr == DATA_PORT);
    assign hit_cmd  = valid && (addr == CMD_PORT);

    always_comb begin
        kind = CYC_NONE;
        if (hit_cmd) begin
            kind = write ? CYC_CMD_WR : CYC_CMD_RD;
        end else if (hit_data) begin
            kind = write ? CYC_DAT_WR : CYC_DAT_RD;
        end
    end

    assign is_gate_cmd = (wdata == GATE_CMD);
    assign is_end_cmd  = (wdata == END_CMD);

endmodule

// File: rtl/kgs_trap_sel.sv
module kgs_trap_sel
    import kgs_pkg::*;
(
    input  cyc_kind_e        kind,
    input  logic [CFG_W-1:0] cfg,
    output logic             port_trap,
    output logic             end_smi
);

    always_comb begin
        unique case (kind)
            CYC_CMD_WR: port_trap = cfg[CFG_CMD_WR];
            CYC_CMD_RD: port_trap = cfg[CFG_CMD_RD];
            CYC_DAT_WR: port_trap = cfg[CFG_DAT_WR];
            CYC_DAT_RD: port_trap = cfg[CFG_DAT_RD];
            default:    port_trap = 1'b0;
        endcase
    end

    assign end_smi = cfg[CFG_SEQ_SMI];

endmodule

// File: rtl/kbd_gate_seq.sv
module kbd_gate_seq
    import kgs_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
    parameter logic [DATA_W-1:0] GATE_CMD  = 'hD1,
    parameter logic [DATA_W-1:0] END_CMD   = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic [CFG_W-1:0]  trap_cfg,
    output logic              fwd_en,
    output logic              smi_pulse,
    output logic              seq_active
);

    cyc_kind_e kind;
    logic      is_gate_cmd;
    logic      is_end_cmd;
    logic      port_trap;
    logic      end_smi;
    seq_regs_t regs_d;
    seq_regs_t regs_q;
    logic      fwd_d;
    logic      bad_end;

    kgs_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DATA_PORT(DATA_PORT),
        .CMD_PORT (CMD_PORT),
        .GATE_CMD (GATE_CMD),
        .END_CMD  (END_CMD)
    ) u_decode (
        .valid      (cyc_valid),
        .addr       (cyc_addr),
        .write      (cyc_write),
        .wdata      (cyc_wdata),
        .kind       (kind),
        .is_gate_cmd(is_gate_cmd),
        .is_end_cmd (is_end_cmd)
    );

    kgs_trap_sel u_trap_sel (
        .kind     (kind),
        .cfg      (trap_cfg),
        .port_trap(port_trap),
        .end_smi  (end_smi)
    );

    // Next-state and decision logic for one cycle
    always_comb begin
        regs_d       = regs_q;
        regs_d.smi   = 1'b0;
        fwd_d        = 1'b0;
        bad_end      = 1'b0;

        if (kind != CYC_NONE) begin
            unique case (regs_q.state)
                ST_IDLE: begin
                    if (kind == CYC_CMD_WR && is_gate_cmd) begin
                        regs_d.state = ST_GATE1;
                        fwd_d        = 1'b1;
                    end else begin
                        fwd_d      = !port_trap;
                        regs_d.smi = port_trap;
                    end
                end
                ST_GATE1: begin
                    unique case (kind)
                        CYC_DAT_WR: begin
                            regs_d.state = ST_GATE2;
                            fwd_d        = 1'b1;
                        end
                        CYC_CMD_WR: begin
                            if (is_gate_cmd) begin
                                fwd_d = 1'b1;
                            end else begin
                                bad_end = 1'b1;
                            end
                        end
                        CYC_CMD_RD: begin
                            fwd_d      = !port_trap;
                            regs_d.smi = port_trap;
                        end
                        default: bad_end = 1'b1;
                    endcase
                end
                ST_GATE2: begin
                    unique case (kind)
                        CYC_CMD_WR: begin
                            if (is_end_cmd) begin
                                regs_d.state = ST_IDLE;
                                fwd_d        = 1'b1;
                                regs_d.smi   = end_smi;
                            end else begin
                                bad_end = 1'b1;
                            end
                        end
                        CYC_CMD_RD: begin
                            fwd_d      = !port_trap;
                            regs_d.smi = port_trap;
                        end
                        default: bad_end = 1'b1;
                    endcase
                end
                default: bad_end = 1'b1;
            endcase

            if (bad_end) begin
                regs_d.state = ST_IDLE;
                fwd_d        = !port_trap;
                regs_d.smi   = port_trap || end_smi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, smi: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign fwd_en     = fwd_d;
    assign smi_pulse  = regs_q.smi;
    assign seq_active = (regs_q.state != ST_IDLE);

endmodule

// File: rtl/kgs_chk.sv
module kgs_chk
    import kgs_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
    parameter logic [DATA_W-1:0] GATE_CMD  = 'hD1,
    parameter logic [DATA_W-1:0] END_CMD   = 'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_valid,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              cyc_write,
    input logic [DATA_W-1:0] cyc_wdata,
    input logic [CFG_W-1:0]  trap_cfg,
    input logic              fwd_en,
    input logic              smi_pulse,
    input logic              seq_active
);

    logic kb_hit;
    logic start_cmd;
    logic end_cmd;
    logic stat_rd;

    assign kb_hit    = cyc_valid && (cyc_addr == DATA_PORT || cyc_addr == CMD_PORT);
    assign start_cmd = cyc_valid && cyc_addr == CMD_PORT && cyc_write && cyc_wdata == GATE_CMD;
    assign end_cmd   = cyc_valid && cyc_addr == CMD_PORT && cyc_write && cyc_wdata == END_CMD;
    assign stat_rd   = cyc_valid && cyc_addr == CMD_PORT && !cyc_write;

    AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_active && start_cmd) |=> seq_active);                         // R2

    AST_START_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_active && start_cmd) |-> fwd_en);                             // R2

    AST_BLOCKED_RAISES_SMI: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_hit && !fwd_en) |=> smi_pulse);                                 // R3

    AST_STATUS_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> $stable(seq_active));                                   // R6

    AST_END_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && end_cmd) |=> !seq_active);                           // R7

    AST_SMI_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> $past(kb_hit));                                       // R9

    AST_NO_FWD_OFF_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_hit |-> !fwd_en);                                               // R10

    AST_FLAG_HELD_OFF_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_hit |=> ($stable(seq_active) && !smi_pulse));                   // R10

endmodule

bind kbd_gate_seq kgs_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DATA_PORT(DATA_PORT),
    .CMD_PORT (CMD_PORT),
    .GATE_CMD (GATE_CMD),
    .END_CMD  (END_CMD)
) u_kgs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .cyc_write (cyc_write),
    .cyc_wdata (cyc_wdata),
    .trap_cfg  (trap_cfg),
    .fwd_en    (fwd_en),
    .smi_pulse (smi_pulse),
    .seq_active(seq_active)
);

// File: tb/tb_kbd_gate_seq.sv
module tb_kbd_gate_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic        cyc_write = 1'b0;
    logic [7:0]  cyc_wdata = '0;
    logic [7:0]  trap_cfg = '0;
    logic        fwd_en;
    logic        smi_pulse;
    logic        seq_active;

    int checks = 0;
    int failures = 0;
    int m_state = 0;   // 0 idle, 1 after D1h, 2 after data byte

    always #2 clk = ~clk;

    kbd_gate_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .cyc_addr  (cyc_addr),
        .cyc_write (cyc_write),
        .cyc_wdata (cyc_wdata),
        .trap_cfg  (trap_cfg),
        .fwd_en    (fwd_en),
        .smi_pulse (smi_pulse),
        .seq_active(seq_active)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Expected behaviour straight from the requirements
    function automatic void model(input int st, input logic v, input logic [15:0] a,
                                  input logic w, input logic [7:0] d, input logic [7:0] c,
                                  output logic fwd, output logic smi, output int nst,
                                  output string tag);
        logic cmd;
        logic dat;
        logic tb;
        cmd = (a == 16'h0064);
        dat = (a == 16'h0060);
        fwd = 1'b0;
        smi = 1'b0;
        nst = st;
        tag = "R10";
        if (!v || !(cmd || dat)) return;
        tb = cmd ? (w ? c[3] : c[2]) : (w ? c[1] : c[0]);
        if (cmd && !w) begin
            fwd = !tb;
            smi = tb;
            tag = (st == 0) ? "R3" : "R6";
            return;
        end
        if (st == 0) begin
            if (cmd && d == 8'hD1) begin
                nst = 1; fwd = 1'b1; tag = "R2";
            end else begin
                fwd = !tb; smi = tb; tag = "R3";
            end
            return;
        end
        if (st == 1 && dat && w) begin
            nst = 2; fwd = 1'b1; tag = "R4"; return;
        end
        if (st == 1 && cmd && d == 8'hD1) begin
            fwd = 1'b1; tag = "R5"; return;
        end
        if (st == 2 && cmd && d == 8'hFF) begin
            nst = 0; fwd = 1'b1; smi = c[7]; tag = "R7"; return;
        end
        nst = 0; fwd = !tb; smi = tb | c[7]; tag = "R8";
    endfunction

    task automatic step(input logic v, input logic [15:0] a, input logic w,
                        input logic [7:0] d, input logic [7:0] c);
        logic  e_fwd;
        logic  e_smi;
        int    e_nst;
        string tag;
        model(m_state, v, a, w, d, c, e_fwd, e_smi, e_nst, tag);
        @(negedge clk);
        cyc_valid = v; cyc_addr = a; cyc_write = w; cyc_wdata = d; trap_cfg = c;
        #1;
        check(tag, "fwd_en", fwd_en, e_fwd);
        @(posedge clk);
        #1;
        check((tag == "R10") ? "R9" : tag, "smi_pulse", smi_pulse, e_smi);
        m_state = e_nst;
        check(tag, "seq_active", seq_active, e_nst != 0);
    endtask

    task automatic idle();
        step(1'b0, 16'h0000, 1'b0, 8'h00, trap_cfg);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  c;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "seq_active", seq_active, 1'b0);
        check("R1", "smi_pulse", smi_pulse, 1'b0);
        check("R1", "fwd_en", fwd_en, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: each kind trapped and passed when idle
        step(1, 16'h64, 1, 8'h20, 8'h08); idle();
        step(1, 16'h64, 0, 8'h00, 8'h04);
        step(1, 16'h60, 1, 8'h55, 8'h02);
        step(1, 16'h60, 0, 8'h00, 8'h01);
        step(1, 16'h60, 0, 8'h00, 8'h0E);
        idle();
        // R2, R4 with all traps set, R6, R7 with bit 7
        step(1, 16'h64, 1, 8'hD1, 8'hFF);
        step(1, 16'h60, 1, 8'h42, 8'hFF);
        step(1, 16'h64, 0, 8'h00, 8'h04);
        step(1, 16'h64, 1, 8'hFF, 8'h80);
        idle();
        // R5 double D1h with bit 3 set, then R8 via a data read with bit 7
        step(1, 16'h64, 1, 8'hD1, 8'h00);
        step(1, 16'h64, 1, 8'hD1, 8'h08);
        step(1, 16'h60, 0, 8'h00, 8'h80);
        // R10 off-port cycle in sequence, then R8 via wrong terminator
        step(1, 16'h64, 1, 8'hD1, 8'h00);
        step(1, 16'h61, 1, 8'hFF, 8'hFF);
        step(1, 16'h60, 1, 8'hDF, 8'h00);
        step(1, 16'h64, 1, 8'h12, 8'h08);
        idle();
        // R8 data write at the second step with no enables
        step(1, 16'h64, 1, 8'hD1, 8'h00);
        step(1, 16'h60, 1, 8'hDD, 8'h00);
        step(1, 16'h60, 1, 8'h01, 8'h00);
        idle();

        c = 8'h00;
        for (int i = 0; i < 4000; i++) begin
            int r;
            if (i % 40 == 0) c = 8'($urandom);
            r = $urandom_range(0, 9);
            a = (r < 4) ? 16'h64 : (r < 8) ? 16'h60 : 16'($urandom);
            r = $urandom_range(0, 9);
            d = (r < 4) ? 8'hD1 : (r < 7) ? 8'hFF : 8'($urandom);
            step(($urandom_range(0, 5) != 0), a, ($urandom_range(0, 3) != 0), d, c);
        end
        idle();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule